// File: doc/BRIEF.md
# Snoop-Coherent Cache Tag Array

This block holds the tags and line-valid flags of a set-associative cache and keeps them coherent with other bus agents such as DMA engines. The cache's own accesses probe it through a lookup port that answers in the same cycle with a hit flag and the way that holds the line. A refill port allocates a way for a missing line, records its tag, and then counts the rows of the line as they arrive from memory. The line becomes valid only when its last row has been stored.

The memory bus that leaves the cache is fed back into the block. Any write on that bus that the cache did not issue is captured in a register and then probed against the tags through a second read port. When the probe hits, the matching way is invalidated through a second clear path. A foreign write that lands on a line that is still being refilled poisons that refill, so the stale line never becomes valid. Data storage and victim selection live outside this block.

Top module: `ctag_array`

## Requirements
- R1: After reset every line is invalid, so no lookup hits until a refill has completed.
- R2: With `lk_valid` high, a lookup whose set holds a valid line with an equal tag drives `lk_hit` high and `lk_way` to that way in the same cycle. With `lk_valid` low, `lk_hit` is low. Address fields are `{tag, set, row, byte}`: byte = bits [2:0], row = bits [4:3], set = bits [7:5], tag = bits [15:8].
- R3: `rf_start` while no refill is running writes the tag of `rf_addr` into way `rf_way` of its set and invalidates that way at the same clock edge. The replaced line misses from the next cycle on.
- R4: Rows arrive in order, one per cycle with `rf_row_we` high. The line becomes valid at the edge where the last of its 4 rows is stored, and not earlier.
- R5: During a refill, a lookup of that line hits with `lk_way = rf_way` when its row has already been stored or arrives in the same cycle. Later rows miss.
- R6: Only bus cycles with `sn_stb` and `sn_we` high and `sn_own` low are snooped. Reads and the cache's own writes leave every line unchanged.
- R7: A foreign write captured at clock edge k to a valid line is invalidated at edge k+1. A lookup between those two edges still hits.
- R8: A captured foreign write whose set and tag equal those of the running refill keeps that line from becoming valid. This includes a capture that coincides with the final row. Stored rows of that line miss from the next cycle on. A foreign write to another line of the same set does not stop the refill from completing.
- R9: `rf_start` while a refill is running is ignored.
- R10: At most one way of a set hits any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_addr | input | 16 | Lookup byte address |
| lk_hit | output | 1 | Lookup found a usable line |
| lk_way | output | 1 | Way that holds the line |
| rf_start | input | 1 | Begin a refill of the line at `rf_addr` |
| rf_addr | input | 16 | Address of the line to allocate |
| rf_way | input | 1 | Way chosen for the allocation |
| rf_row_we | input | 1 | One row of the refilling line is stored this cycle |
| sn_stb | input | 1 | Looped-back bus strobe |
| sn_we | input | 1 | Looped-back bus write enable |
| sn_own | input | 1 | Bus cycle was issued by this cache |
| sn_addr | input | 16 | Looped-back bus address |

## Verification
Two functions can act on the same line in the same cycle: the snoop invalidation and the completion of a refill. The bench provokes this by issuing a foreign write one cycle before the final row, so the registered probe meets the completion edge. It does this once with the refilling line's own address, where the line must stay invalid, and once with another line of the same set, where it must become valid. It also overlaps lookups with row arrival, so that the bypass of a row landing in the same cycle is judged against a cycle-accurate reference model.

// File: rtl/cache_tag_pkg.sv
`timescale 1ns/1ps
package cache_tag_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    function automatic int unsigned bits_for(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctag_store.sv
`timescale 1ns/1ps
module ctag_store
    import cache_tag_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int IDX_W = bits_for(SETS),
    localparam int WAY_W = bits_for(WAYS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_en,
    input  logic [IDX_W-1:0]                alloc_set,
    input  logic [WAY_W-1:0]                alloc_way,
    input  logic [TAG_W-1:0]                alloc_tag,
    input  logic                            mark_en,
    input  logic [IDX_W-1:0]                mark_set,
    input  logic [WAY_W-1:0]                mark_way,
    input  logic                            drop_en,
    input  logic [IDX_W-1:0]                drop_set,
    input  logic [WAY_W-1:0]                drop_way,
    input  logic [IDX_W-1:0]                rd_a_set,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_a_tag,
    output logic [WAYS-1:0]                 rd_a_vld,
    input  logic [IDX_W-1:0]                rd_b_set,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_b_tag,
    output logic [WAYS-1:0]                 rd_b_vld
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]              vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
    } store_t;

    store_t store_d, store_q;

    // Valid-flag writers, later ones win: mark, then allocate, then snoop drop.
    always_comb begin
        store_d = store_q;
        if (mark_en) begin
            store_d.vld[mark_set][mark_way] = 1'b1;
        end
        if (alloc_en) begin
            store_d.tag[alloc_set][alloc_way] = alloc_tag;
            store_d.vld[alloc_set][alloc_way] = 1'b0;
        end
        if (drop_en) begin
            store_d.vld[drop_set][drop_way] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    // Two independent read ports: cache lookup and snoop probe.
    assign rd_a_tag = store_q.tag[rd_a_set];
    assign rd_a_vld = store_q.vld[rd_a_set];
    assign rd_b_tag = store_q.tag[rd_b_set];
    assign rd_b_vld = store_q.vld[rd_b_set];

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (store_q.vld == '0));

    a_r7_drop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |=> !store_q.vld[$past(drop_set)][$past(drop_way)]);

    a_r3_alloc_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (!store_q.vld[$past(alloc_set)][$past(alloc_way)] &&
                      store_q.tag[$past(alloc_set)][$past(alloc_way)] == $past(alloc_tag)));

    a_r4_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en &&
         !(alloc_en && alloc_set == mark_set && alloc_way == mark_way) &&
         !(drop_en && drop_set == mark_set && drop_way == mark_way))
        |=> store_q.vld[$past(mark_set)][$past(mark_way)]);

endmodule

// File: rtl/ctag_match.sv
`timescale 1ns/1ps
module ctag_match
    import cache_tag_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int WAY_W = bits_for(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0]             vld,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);

    logic [WAYS-1:0] way_hit;

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
        assign way_hit[gw] = vld[gw] && (tags[gw] == probe_tag);
    end

    always_comb begin
        way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (way_hit[i]) begin
                way = WAY_W'(i);
            end
        end
    end

    assign hit = |way_hit;

    a_r10_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

endmodule

// File: rtl/ctag_snoop.sv
`timescale 1ns/1ps
module ctag_snoop #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic              bus_own,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              pend,
    output logic [ADDR_W-1:0] pend_addr
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
    } snoop_t;

    snoop_t snp_d, snp_q;

    always_comb begin
        snp_d      = snp_q;
        snp_d.pend = bus_stb && bus_we && !bus_own;
        if (snp_d.pend) begin
            snp_d.addr = bus_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_q <= '0;
        end else begin
            snp_q <= snp_d;
        end
    end

    assign pend      = snp_q.pend;
    assign pend_addr = snp_q.addr;

    a_r6_own_or_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own || !bus_we || !bus_stb) |=> !pend);

endmodule

// File: rtl/ctag_refill.sv
`timescale 1ns/1ps
module ctag_refill
    import cache_tag_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int IDX_W = 3,
    parameter int TAG_W = 8,
    parameter int WAY_W = 1,
    localparam int ROW_W = bits_for(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_set,
    input  logic [TAG_W-1:0] start_tag,
    input  logic [WAY_W-1:0] start_way,
    input  logic             row_we,
    input  logic             kill,
    output logic             busy,
    output logic [IDX_W-1:0] cur_set,
    output logic [TAG_W-1:0] cur_tag,
    output logic [WAY_W-1:0] cur_way,
    output logic [ROW_W-1:0] rows_done,
    output logic             poisoned,
    output logic             alloc_fire,
    output logic             complete_ok
);

    typedef struct packed {
        fill_state_e      st;
        logic [IDX_W-1:0] set;
        logic [TAG_W-1:0] tag;
        logic [WAY_W-1:0] way;
        logic [ROW_W-1:0] cnt;
        logic             poison;
    } fill_t;

    fill_t fill_d, fill_q;
    logic  last_row;

    always_comb begin
        fill_d      = fill_q;
        alloc_fire  = 1'b0;
        complete_ok = 1'b0;
        last_row    = (fill_q.st == FILL_BUSY) && row_we &&
                      (fill_q.cnt == ROW_W'(ROWS - 1));
        if (fill_q.st == FILL_IDLE) begin
            if (start) begin
                alloc_fire    = 1'b1;
                fill_d.st     = FILL_BUSY;
                fill_d.set    = start_set;
                fill_d.tag    = start_tag;
                fill_d.way    = start_way;
                fill_d.cnt    = '0;
                fill_d.poison = 1'b0;
            end
        end else if (last_row) begin
            // A snoop arriving with the final row still blocks the line.
            complete_ok   = !fill_q.poison && !kill;
            fill_d.st     = FILL_IDLE;
            fill_d.cnt    = '0;
            fill_d.poison = 1'b0;
        end else begin
            if (row_we) begin
                fill_d.cnt = fill_q.cnt + 1'b1;
            end
            if (kill) begin
                fill_d.poison = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign busy      = (fill_q.st == FILL_BUSY);
    assign cur_set   = fill_q.set;
    assign cur_tag   = fill_q.tag;
    assign cur_way   = fill_q.way;
    assign rows_done = fill_q.cnt;
    assign poisoned  = fill_q.poison;

    a_r4_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && row_we && rows_done == ROW_W'(ROWS - 1)) |=> !busy);

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last_row) |=>
            (busy && cur_tag == $past(cur_tag) && cur_set == $past(cur_set) &&
             cur_way == $past(cur_way)));

    a_r8_poison_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        poisoned |-> !complete_ok);

endmodule

// File: rtl/ctag_array.sv
`timescale 1ns/1ps
module ctag_array
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SETS       = 8,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 32,
    parameter int ROW_BYTES  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_valid,
    input  logic [ADDR_W-1:0]           lk_addr,
    output logic                        lk_hit,
    output logic [bits_for(WAYS)-1:0]   lk_way,
    input  logic                        rf_start,
    input  logic [ADDR_W-1:0]           rf_addr,
    input  logic [bits_for(WAYS)-1:0]   rf_way,
    input  logic                        rf_row_we,
    input  logic                        sn_stb,
    input  logic                        sn_we,
    input  logic                        sn_own,
    input  logic [ADDR_W-1:0]           sn_addr
);

    localparam int ROW_OFF = $clog2(ROW_BYTES);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int ROWS    = LINE_BYTES / ROW_BYTES;
    localparam int ROW_W   = bits_for(ROWS);
    localparam int IDX_W   = bits_for(SETS);
    localparam int WAY_W   = bits_for(WAYS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

    // Address fields
    logic [IDX_W-1:0] lk_set, rf_set, sp_set;
    logic [TAG_W-1:0] lk_tag, rf_tag, sp_tag;
    logic [ROW_W-1:0] lk_row;
    logic             sp_pend;
    logic [ADDR_W-1:0] sp_addr;

    assign lk_set = lk_addr[OFF_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_row = lk_addr[ROW_OFF +: ROW_W];
    assign rf_set = rf_addr[OFF_W +: IDX_W];
    assign rf_tag = rf_addr[ADDR_W-1 -: TAG_W];
    assign sp_set = sp_addr[OFF_W +: IDX_W];
    assign sp_tag = sp_addr[ADDR_W-1 -: TAG_W];

    logic unused_low_bits;
    assign unused_low_bits = ^{lk_addr[ROW_OFF-1:0], rf_addr[OFF_W-1:0], sp_addr[OFF_W-1:0]};

    // Submodule interconnect
    logic [WAYS-1:0][TAG_W-1:0] a_tags, b_tags;
    logic [WAYS-1:0]            a_vld, b_vld;
    logic                       a_hit, b_hit;
    logic [WAY_W-1:0]           a_way, b_way;
    logic                       f_busy, f_poison, f_alloc, f_done;
    logic [IDX_W-1:0]           f_set;
    logic [TAG_W-1:0]           f_tag;
    logic [WAY_W-1:0]           f_way;
    logic [ROW_W-1:0]           f_rows;
    logic                       drop_en, kill, fill_hit;

    ctag_snoop #(.ADDR_W(ADDR_W)) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_stb   (sn_stb),
        .bus_we    (sn_we),
        .bus_own   (sn_own),
        .bus_addr  (sn_addr),
        .pend      (sp_pend),
        .pend_addr (sp_addr)
    );

    ctag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (f_alloc),
        .alloc_set (rf_set),
        .alloc_way (rf_way),
        .alloc_tag (rf_tag),
        .mark_en   (f_done),
        .mark_set  (f_set),
        .mark_way  (f_way),
        .drop_en   (drop_en),
        .drop_set  (sp_set),
        .drop_way  (b_way),
        .rd_a_set  (lk_set),
        .rd_a_tag  (a_tags),
        .rd_a_vld  (a_vld),
        .rd_b_set  (sp_set),
        .rd_b_tag  (b_tags),
        .rd_b_vld  (b_vld)
    );

    ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .tags      (a_tags),
        .vld       (a_vld),
        .probe_tag (lk_tag),
        .hit       (a_hit),
        .way       (a_way)
    );

    ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .tags      (b_tags),
        .vld       (b_vld),
        .probe_tag (sp_tag),
        .hit       (b_hit),
        .way       (b_way)
    );

    ctag_refill #(.ROWS(ROWS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_refill (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (rf_start),
        .start_set   (rf_set),
        .start_tag   (rf_tag),
        .start_way   (rf_way),
        .row_we      (rf_row_we),
        .kill        (kill),
        .busy        (f_busy),
        .cur_set     (f_set),
        .cur_tag     (f_tag),
        .cur_way     (f_way),
        .rows_done   (f_rows),
        .poisoned    (f_poison),
        .alloc_fire  (f_alloc),
        .complete_ok (f_done)
    );

    // Snoop side: clear a valid hit, poison a matching in-flight refill.
    assign drop_en = sp_pend && b_hit;
    assign kill    = sp_pend && f_busy && (sp_set == f_set) && (sp_tag == f_tag);

    // Lookup side: rows of the line under refill, including the one landing now.
    always_comb begin
        fill_hit = 1'b0;
        if (f_busy && !f_poison && lk_set == f_set && lk_tag == f_tag) begin
            fill_hit = (lk_row < f_rows) || (rf_row_we && lk_row == f_rows);
        end
        lk_hit = lk_valid && (a_hit || fill_hit);
        lk_way = a_hit ? a_way : f_way;
    end

    a_r5_fill_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        fill_hit |-> !a_hit);

    a_r7_snoop_clears_next: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pend && b_hit) |=> !(lk_valid && lk_set == $past(sp_set) &&
                                 lk_tag == $past(sp_tag) && a_hit &&
                                 !$past(f_alloc) && !$past(f_done)));

endmodule

// File: tb/ctag_array_test.sv
`timescale 1ns/1ps
module ctag_array_test;

    localparam int ADDR_W = 16;
    localparam int SETS   = 8;
    localparam int WAYS   = 2;
    localparam int ROWS   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_valid;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [0:0]        lk_way;
    logic              rf_start;
    logic [ADDR_W-1:0] rf_addr;
    logic [0:0]        rf_way;
    logic              rf_row_we;
    logic              sn_stb, sn_we, sn_own;
    logic [ADDR_W-1:0] sn_addr;

    always #2 clk = ~clk;

    ctag_array #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
                 .LINE_BYTES(32), .ROW_BYTES(8)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_way(lk_way), .rf_start(rf_start), .rf_addr(rf_addr),
        .rf_way(rf_way), .rf_row_we(rf_row_we), .sn_stb(sn_stb), .sn_we(sn_we),
        .sn_own(sn_own), .sn_addr(sn_addr)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural reference state
    bit m_vld[SETS][WAYS];
    int m_tag[SETS][WAYS];
    bit f_busy, f_poison;
    int f_set, f_tag, f_way, f_cnt;
    bit s_pend;
    int s_addr;

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int r);
        return ADDR_W'((t << 8) | (s << 5) | (r << 3));
    endfunction
    function automatic int tg(int a); return (a >> 8) & 255; endfunction
    function automatic int st(int a); return (a >> 5) & 7;   endfunction
    function automatic int rw(int a); return (a >> 3) & 3;   endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0;
                m_tag[s][w] = 0;
            end
        f_busy = 0; f_poison = 0; f_cnt = 0; f_set = 0; f_tag = 0; f_way = 0;
        s_pend = 0; s_addr = 0;
    endtask

    task automatic idle();
        lk_valid = 0; lk_addr = '0; rf_start = 0; rf_addr = '0; rf_way = '0;
        rf_row_we = 0; sn_stb = 0; sn_we = 0; sn_own = 0; sn_addr = '0;
    endtask

    function automatic bit present(int a);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[st(a)][w] && m_tag[st(a)][w] == tg(a)) return 1;
        return 0;
    endfunction

    // One clock: check outputs mid-cycle, then advance the model on the edge.
    task automatic step(string req);
        bit eh;
        int ew;
        int a;
        bit clr, kill;
        int cs, cw;
        #1;
        eh = 0; ew = 0;
        a = int'(lk_addr);
        if (lk_valid) begin
            for (int w = 0; w < WAYS; w++)
                if (m_vld[st(a)][w] && m_tag[st(a)][w] == tg(a)) begin
                    eh = 1; ew = w;
                end
            if (!eh && f_busy && !f_poison && st(a) == f_set && tg(a) == f_tag &&
                (rw(a) < f_cnt || (rf_row_we && rw(a) == f_cnt))) begin
                eh = 1; ew = f_way;
            end
        end
        total++;
        if (lk_hit !== eh || (eh && lk_way !== 1'(ew))) begin
            bad++;
            $display("FAIL %s: addr=%h hit/way actual=%b/%0d expected=%b/%0d",
                     req, lk_addr, lk_hit, lk_way, eh, ew);
        end
        @(posedge clk);
        clr = 0; kill = 0; cs = 0; cw = 0;
        if (s_pend) begin
            for (int w = 0; w < WAYS; w++)
                if (m_vld[st(s_addr)][w] && m_tag[st(s_addr)][w] == tg(s_addr)) begin
                    clr = 1; cs = st(s_addr); cw = w;
                end
            if (f_busy && f_set == st(s_addr) && f_tag == tg(s_addr)) kill = 1;
        end
        if (rf_start && !f_busy) begin
            a = int'(rf_addr);
            m_tag[st(a)][rf_way] = tg(a);
            m_vld[st(a)][rf_way] = 0;
            f_busy = 1; f_set = st(a); f_tag = tg(a); f_way = rf_way;
            f_cnt = 0; f_poison = 0;
        end else if (f_busy) begin
            if (rf_row_we && f_cnt == ROWS - 1) begin
                if (!f_poison && !kill) m_vld[f_set][f_way] = 1;
                f_busy = 0; f_cnt = 0; f_poison = 0;
            end else begin
                if (rf_row_we) f_cnt++;
                if (kill) f_poison = 1;
            end
        end
        if (clr) m_vld[cs][cw] = 0;
        s_pend = sn_stb && sn_we && !sn_own;
        if (s_pend) s_addr = int'(sn_addr);
        @(negedge clk);
    endtask

    task automatic look(string req, int t, int s, int r);
        lk_valid = 1; lk_addr = mk(t, s, r);
        step(req);
        lk_valid = 0;
    endtask

    task automatic begin_fill(string req, int t, int s, int w);
        rf_start = 1; rf_addr = mk(t, s, 0); rf_way = 1'(w);
        step(req);
        rf_start = 0;
    endtask

    task automatic row(string req, int lt, int ls, int lr);
        rf_row_we = 1; lk_valid = 1; lk_addr = mk(lt, ls, lr);
        step(req);
        rf_row_we = 0; lk_valid = 0;
    endtask

    task automatic snoop(string req, bit we, bit own, int t, int s, int r);
        sn_stb = 1; sn_we = we; sn_own = own; sn_addr = mk(t, s, r);
        step(req);
        sn_stb = 0; sn_we = 0; sn_own = 0;
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: nothing hits after reset
        look("R1", 0, 0, 0);
        look("R1", 5, 1, 2);

        // R3 allocate, R5 same-cycle row bypass, R4 valid only after last row
        begin_fill("R3", 5, 1, 0);
        row("R5", 5, 1, 0);
        row("R4", 5, 1, 3);
        row("R5", 5, 1, 1);
        look("R5", 5, 1, 2);
        look("R4", 5, 1, 3);
        row("R5", 5, 1, 3);
        look("R4", 5, 1, 3);
        look("R4", 5, 1, 0);

        // R2 second way, R10 single-way hits
        begin_fill("R3", 9, 1, 1);
        repeat (4) row("R5", 9, 1, 2);
        look("R2", 9, 1, 1);
        look("R10", 5, 1, 1);
        look("R2", 7, 1, 1);
        lk_addr = mk(9, 1, 0); lk_valid = 0;
        step("R2");

        // R6 own writes and reads are ignored
        snoop("R6", 1, 1, 5, 1, 0);
        look("R6", 5, 1, 0);
        snoop("R6", 0, 0, 5, 1, 0);
        look("R6", 5, 1, 0);
        look("R6", 5, 1, 3);

        // R7 foreign write: still hits one cycle, gone the next
        snoop("R7", 1, 0, 5, 1, 2);
        look("R7", 5, 1, 2);
        look("R7", 5, 1, 2);
        look("R7", 9, 1, 0);

        // R3 replacing a valid line makes it miss
        begin_fill("R3", 4, 1, 1);
        look("R3", 9, 1, 0);
        repeat (4) row("R4", 4, 1, 0);

        // R9 start ignored while busy; R8 snoop poisons an in-flight fill
        begin_fill("R3", 7, 2, 0);
        row("R5", 7, 2, 0);
        rf_start = 1; rf_addr = mk(8, 3, 0); rf_way = 1'b1;
        step("R9");
        rf_start = 0;
        snoop("R8", 1, 0, 7, 2, 3);
        look("R8", 7, 2, 0);
        look("R8", 7, 2, 0);
        repeat (3) row("R8", 7, 2, 1);
        look("R8", 7, 2, 0);
        look("R9", 8, 3, 0);

        // R8 foreign write to another line of the set, landing with the last row
        begin_fill("R3", 3, 4, 1);
        row("R5", 3, 4, 0);
        row("R5", 3, 4, 1);
        rf_row_we = 1; sn_stb = 1; sn_we = 1; sn_addr = mk(6, 4, 0);
        step("R8");
        sn_stb = 0; sn_we = 0;
        row("R8", 3, 4, 3);
        look("R8", 3, 4, 2);

        // R8 matching foreign write landing with the last row
        begin_fill("R3", 2, 5, 0);
        row("R5", 2, 5, 0);
        row("R5", 2, 5, 1);
        rf_row_we = 1; sn_stb = 1; sn_we = 1; sn_addr = mk(2, 5, 1);
        step("R8");
        sn_stb = 0; sn_we = 0;
        row("R8", 2, 5, 3);
        look("R8", 2, 5, 0);

        // Mixed traffic compared against the model each cycle (R2 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < 600; i++) begin
            int ra;
            lk_valid  = ($urandom % 4) != 0;
            lk_addr   = mk($urandom % 3, $urandom % 2, $urandom % 4);
            rf_row_we = ($urandom % 2) != 0;
            ra        = int'(mk($urandom % 3, $urandom % 2, 0));
            rf_start  = 0;
            if (($urandom % 6) == 0 && !present(ra) &&
                !(f_busy && st(ra) == f_set && tg(ra) == f_tag)) begin
                rf_start = 1;
            end
            rf_addr = ADDR_W'(ra);
            rf_way  = 1'($urandom % 2);
            sn_stb  = ($urandom % 4) == 0;
            sn_we   = ($urandom % 3) != 0;
            sn_own  = ($urandom % 3) == 0;
            sn_addr = mk($urandom % 3, $urandom % 2, $urandom % 4);
            step("R10-mixed");
        end
        idle();
        step("R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule